// File: doc/BRIEF.md
# Framed Rate-1/2 Convolutional Encoder

This block turns a serial bit stream into a rate-1/2 convolutional code with constraint length 7. Each accepted data bit yields two coded bits per clock: an I bit from generator 171 (octal) and a Q bit from generator 133 (octal). The data is organised in blocks. A framing controller opens a block on a qualified start and closes it on a qualified end. After the end it shifts six zeros through the encoder, so that the encoder is back in the all-zero state for the decoder on the far side.

Upstream logic presents one bit per clock with a valid strobe, and marks the first and last bits with start and end strobes. Downstream logic sees a registered output valid, together with one-cycle markers on the first and the last coded pair of the block. Output valid drops when the upstream valid drops inside a block. During the flush, output valid stays high whatever the upstream valid does.

Top module: `framed_conv_enc`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is 0 after that edge, whatever the other inputs are.
- R2: For each coded pair, the window is {d, h5, h4, h3, h2, h1, h0}, with d the bit being encoded in window bit 6, h5 the newest earlier bit and h0 the oldest. `code_i` is the XOR of the window bits selected by 7'b1111001 (171 octal), and `code_q` is the XOR of those selected by 7'b1011011 (133 octal).
- R3: A start is accepted when `dval_i` and `bstart_i` are both high at an edge. It clears the history before that cycle's `din` is encoded. After that edge, `dval_o` and `bstart_o` are 1, and `bstart_o` returns to 0 at the next edge unless another start is accepted.
- R4: `bstart_i` or `bend_i` with `dval_i` low has no effect; outside a block, `dval_o` stays 0.
- R5: An end (`dval_i` and `bend_i` high) while no block is open is ignored: `dval_o` stays 0.
- R6: The `din` presented with an accepted end is encoded as the last data bit. Six coded pairs follow with zero as input, and `bstop_o` is 1 only on the sixth of them. `dval_o` falls at the seventh edge after the end edge.
- R7: During the six-zero flush, `dval_i` low does not pause output: `dval_o` stays 1 until the flush completes.
- R8: In an open block (not flushing), an edge with `dval_i` low makes `dval_o` 0 after that edge and leaves the history unchanged. Encoding resumes with that history when `dval_i` returns high.
- R9: Whenever `dval_o` is 0, `code_i` and `code_q` are 0.
- R10: An accepted start during an open block or during a flush discards the history and any flush in progress, and begins a new block as in R3.
- R11: When start and end are accepted in the same cycle, the start wins and the block stays open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Data bit |
| dval_i | input | 1 | Data valid; qualifies din, bstart_i and bend_i |
| bstart_i | input | 1 | First bit of a block |
| bend_i | input | 1 | Last bit of a block |
| code_i | output | 1 | Coded bit, generator 171 octal |
| code_q | output | 1 | Coded bit, generator 133 octal |
| dval_o | output | 1 | Coded pair valid |
| bstart_o | output | 1 | First coded pair of a block |
| bstop_o | output | 1 | Last coded pair of a block (end of flush) |

## Verification
The bench goes after the framing corners:
- An end with no open block. A design that opened on it would raise `dval_o`.
- Valid dropping mid-flush. A design that paused there would lose flush pairs and leave the decoder's final state wrong.
- Valid dropping mid-block. A design that cleared or shifted the history would corrupt the bits after resumption.
- A start arriving inside a block or a flush. A design that kept the old history would emit wrong first pairs.
- Start and end together.

Long pseudo-random blocks compare every coded pair against an independent model of both generators. This catches a wrong tap, a swapped channel or a reversed history order.

// File: rtl/fce_pkg.sv
`timescale 1ns/1ps
// Shared types for the framed convolutional encoder.
package fce_pkg;
    // Framing controller state.
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_OPEN  = 2'd1,
        FR_FLUSH = 2'd2
    } frame_state_e;
endpackage

// File: rtl/fce_shift_core.sv
`timescale 1ns/1ps
// Shift register and generator taps of the convolutional code.
// Assumes the controller raises clr only together with adv. The window
// places the current bit at the MSB and older bits at lower positions.
module fce_shift_core #(
    parameter int unsigned      K      = 7,
    parameter logic [K-1:0]     POLY_I = 7'o171,
    parameter logic [K-1:0]     POLY_Q = 7'o133
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  logic       adv,
    input  logic       clr,
    input  logic       zero_in,
    output logic [1:0] code,
    output logic       hist_zero
);
    localparam int unsigned MEM = K - 1;
    localparam logic [1:0][K-1:0] POLYS = {POLY_Q, POLY_I};

    logic [MEM-1:0] hist;
    logic [MEM-1:0] hist_base;
    logic           d_eff;
    logic [K-1:0]   window;

    // Select the history seen this cycle and the bit to encode.
    always_comb begin
        hist_base = clr ? '0 : hist;
        d_eff     = zero_in ? 1'b0 : din;
        window    = {d_eff, hist_base};
    end

    // One parity tree per generator.
    for (genvar g = 0; g < 2; g++) begin : g_tap
        assign code[g] = ^(window & POLYS[g]);
    end

    // Shift the encoded bit in as the newest history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (adv) begin
            hist <= {d_eff, hist_base[MEM-1:1]};
        end
    end

    assign hist_zero = (hist == '0);

    AST_CLEAR_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && adv) |=> (hist[MEM-2:0] == '0)); // R10

    AST_HOLD_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(hist)); // R8
endmodule

// File: rtl/fce_frame_ctrl.sv
`timescale 1ns/1ps
// Block framing controller: qualifies start/end with valid, orders them,
// and runs a fixed-length zero flush after each end. Start has priority.
module fce_frame_ctrl
    import fce_pkg::*;
#(
    parameter int unsigned FLUSH_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dval_i,
    input  logic bstart_i,
    input  logic bend_i,
    output logic adv,
    output logic clr,
    output logic zero_in,
    output logic emit,
    output logic first,
    output logic last,
    output logic blk_open,
    output logic flushing
);
    localparam int unsigned CW = $clog2(FLUSH_LEN + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FLUSH_LEN - 1);

    frame_state_e st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          start_acc;

    assign start_acc = dval_i && bstart_i;

    // Next-state and per-cycle strobes of the framing FSM.
    always_comb begin
        adv     = 1'b0;
        clr     = 1'b0;
        zero_in = 1'b0;
        emit    = 1'b0;
        first   = 1'b0;
        last    = 1'b0;
        st_nx   = st;
        cnt_nx  = cnt;
        if (start_acc) begin
            adv    = 1'b1;
            clr    = 1'b1;
            emit   = 1'b1;
            first  = 1'b1;
            st_nx  = FR_OPEN;
            cnt_nx = '0;
        end else begin
            case (st)
                FR_OPEN: begin
                    if (dval_i) begin
                        adv  = 1'b1;
                        emit = 1'b1;
                        if (bend_i) begin
                            st_nx  = FR_FLUSH;
                            cnt_nx = '0;
                        end
                    end
                end
                FR_FLUSH: begin
                    adv     = 1'b1;
                    zero_in = 1'b1;
                    emit    = 1'b1;
                    if (cnt == CNT_LAST) begin
                        last   = 1'b1;
                        st_nx  = FR_IDLE;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // State and flush counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= FR_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    assign blk_open = (st == FR_OPEN);
    assign flushing = (st == FR_FLUSH);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(FLUSH_LEN)); // R6

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !flushing |-> cnt == '0); // R6
endmodule

// File: rtl/fce_out_stage.sv
`timescale 1ns/1ps
// Output register stage; coded bits are forced to zero when not emitting.
module fce_out_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       emit,
    input  logic       first,
    input  logic       last,
    input  logic [1:0] code,
    output logic       code_i,
    output logic       code_q,
    output logic       dval_o,
    output logic       bstart_o,
    output logic       bstop_o
);
    // Register the coded pair and its framing markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_i   <= 1'b0;
            code_q   <= 1'b0;
            dval_o   <= 1'b0;
            bstart_o <= 1'b0;
            bstop_o  <= 1'b0;
        end else begin
            code_i   <= emit & code[0];
            code_q   <= emit & code[1];
            dval_o   <= emit;
            bstart_o <= first;
            bstop_o  <= last;
        end
    end

    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dval_o |-> (!code_i && !code_q)); // R9

    AST_STOP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bstop_o |-> dval_o); // R6
endmodule

// File: rtl/framed_conv_enc.sv
`timescale 1ns/1ps
// Top of the framed rate-1/2 convolutional encoder: framing controller,
// shift core and output register. Output latency is one clock.
module framed_conv_enc #(
    parameter int unsigned      K      = 7,
    parameter logic [K-1:0]     POLY_I = 7'o171,
    parameter logic [K-1:0]     POLY_Q = 7'o133
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic dval_i,
    input  logic bstart_i,
    input  logic bend_i,
    output logic code_i,
    output logic code_q,
    output logic dval_o,
    output logic bstart_o,
    output logic bstop_o
);
    localparam int unsigned FLUSH_LEN = K - 1;

    logic       adv, clr, zero_in, emit, first, last;
    logic       blk_open, flushing, hist_zero;
    logic [1:0] code;

    fce_frame_ctrl #(.FLUSH_LEN(FLUSH_LEN)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .dval_i(dval_i), .bstart_i(bstart_i),
        .bend_i(bend_i), .adv(adv), .clr(clr), .zero_in(zero_in),
        .emit(emit), .first(first), .last(last), .blk_open(blk_open),
        .flushing(flushing)
    );

    fce_shift_core #(.K(K), .POLY_I(POLY_I), .POLY_Q(POLY_Q)) core_i (
        .clk(clk), .rst_n(rst_n), .din(din), .adv(adv), .clr(clr),
        .zero_in(zero_in), .code(code), .hist_zero(hist_zero)
    );

    fce_out_stage out_i (
        .clk(clk), .rst_n(rst_n), .emit(emit), .first(first), .last(last),
        .code(code), .code_i(code_i), .code_q(code_q), .dval_o(dval_o),
        .bstart_o(bstart_o), .bstop_o(bstop_o)
    );

    AST_START_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (dval_i && bstart_i) |=> (dval_o && bstart_o)); // R3

    AST_STOP_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bstop_o && !(dval_i && bstart_i)) |=> !dval_o); // R6

    AST_FLUSHED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bstop_o |-> hist_zero); // R6

    AST_FLUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        flushing |=> dval_o); // R7

    AST_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dval_i && !flushing) |=> !dval_o); // R8

    AST_END_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_open && !flushing && dval_i && bend_i && !bstart_i) |=> !dval_o); // R5

    AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (dval_i && bstart_i && bend_i) |=> blk_open); // R11
endmodule

// File: tb/framed_conv_enc_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes each expected output pair from a
// behavioural model and queues it; the monitor compares after each edge.
module framed_conv_enc_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0, dval_i = 1'b0, bstart_i = 1'b0, bend_i = 1'b0;
    logic code_i, code_q, dval_o, bstart_o, bstop_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    // Behavioural model state.
    bit       m_open = 1'b0, m_flush = 1'b0;
    int       m_cnt = 0;
    bit [5:0] m_hist = '0;
    bit [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    framed_conv_enc dut_i (
        .clk(clk), .rst_n(rst_n), .din(din), .dval_i(dval_i),
        .bstart_i(bstart_i), .bend_i(bend_i), .code_i(code_i),
        .code_q(code_q), .dval_o(dval_o), .bstart_o(bstart_o),
        .bstop_o(bstop_o)
    );

    // Drive one cycle of inputs and queue the output expected after the edge.
    task automatic cyc(input bit dv, input bit st, input bit en, input bit d,
                       input string tag);
        bit emit, first, last, zero;
        bit di, ei, eq;
        bit [6:0] w;
        @(negedge clk);
        dval_i = dv; bstart_i = st; bend_i = en; din = d;
        emit = 0; first = 0; last = 0; zero = 0;
        if (dv && st) begin
            m_hist = '0; emit = 1; first = 1;
            m_open = 1; m_flush = 0; m_cnt = 0;
        end else if (m_flush) begin
            emit = 1; zero = 1;
            if (m_cnt == 5) begin last = 1; m_flush = 0; m_cnt = 0; end
            else m_cnt++;
        end else if (m_open && dv) begin
            emit = 1;
            if (en) begin m_open = 0; m_flush = 1; m_cnt = 0; end
        end
        ei = 0; eq = 0;
        if (emit) begin
            di = zero ? 1'b0 : d;
            w  = {di, m_hist};
            ei = ^(w & 7'b1111001);
            eq = ^(w & 7'b1011011);
            m_hist = {di, m_hist[5:1]};
        end
        exp_q.push_back({emit, ei, eq, first, last});
        tag_q.push_back(tag);
    endtask

    function automatic bit next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // Monitor: compare each registered output against the queued item.
    always @(posedge clk) begin
        #2;
        if (rst_n && exp_q.size() > 0) begin
            logic [4:0] e, g;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            g = {dval_o, code_i, code_q, bstart_o, bstop_o};
            checks++;
            if (g !== e) begin
                errors++;
                $display("FAIL %s: {dval,i,q,bstart,bstop} got %b expected %b",
                         t, g, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset dominates active inputs.
        dval_i = 1; bstart_i = 1; din = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({dval_o, code_i, code_q, bstart_o, bstop_o} !== 5'b0) begin
            errors++;
            $display("FAIL R1: outputs got %b expected 00000",
                     {dval_o, code_i, code_q, bstart_o, bstop_o});
        end
        dval_i = 0; bstart_i = 0; din = 0;
        rst_n = 1;

        // R4: start/end without valid; R5: end with no open block.
        cyc(0, 1, 0, 1, "R4");
        cyc(0, 0, 1, 1, "R4");
        cyc(1, 0, 1, 1, "R5");
        cyc(1, 0, 0, 1, "R5");
        cyc(0, 0, 0, 0, "R9");

        // R2/R3/R6: a short block with a fixed pattern.
        cyc(1, 1, 0, 1, "R3");
        for (int i = 0; i < 18; i++) cyc(1, 0, 0, (i % 3) == 1, "R2");
        cyc(1, 0, 1, 1, "R6");
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 1, "R6");
        cyc(1, 0, 0, 1, "R6");
        cyc(0, 0, 0, 0, "R9");

        // R8/R9: pauses mid-block keep the history.
        cyc(1, 1, 0, 1, "R3");
        cyc(1, 0, 0, 1, "R8");
        cyc(0, 0, 0, 1, "R8");
        cyc(0, 0, 1, 0, "R8");
        cyc(1, 0, 0, 0, "R8");
        cyc(1, 0, 0, 1, "R8");
        cyc(0, 0, 0, 1, "R9");
        cyc(1, 0, 0, 1, "R8");
        // R7: valid drops during the flush.
        cyc(1, 0, 1, 0, "R6");
        cyc(0, 0, 0, 1, "R7");
        cyc(0, 0, 0, 0, "R7");
        cyc(1, 0, 0, 1, "R7");
        cyc(0, 0, 1, 1, "R7");
        cyc(0, 0, 0, 0, "R7");
        cyc(0, 0, 0, 0, "R7");
        cyc(0, 0, 0, 0, "R9");

        // R10: restart inside a block and inside a flush.
        cyc(1, 1, 0, 1, "R3");
        cyc(1, 0, 0, 1, "R10");
        cyc(1, 0, 0, 1, "R10");
        cyc(1, 1, 0, 0, "R10");
        cyc(1, 0, 0, 1, "R10");
        cyc(1, 0, 1, 1, "R10");
        cyc(1, 0, 0, 0, "R10");
        cyc(1, 0, 0, 0, "R10");
        cyc(1, 1, 0, 1, "R10");
        cyc(1, 0, 0, 1, "R10");
        // R11: start and end together keep the block open.
        cyc(1, 1, 1, 1, "R11");
        cyc(1, 0, 0, 1, "R11");
        cyc(1, 0, 0, 0, "R11");
        cyc(1, 0, 1, 1, "R11");
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, "R6");

        // R2: long pseudo-random blocks with random pauses.
        for (int b = 0; b < 4; b++) begin
            cyc(1, 1, 0, next_bit(), "R3");
            for (int i = 0; i < 150; i++) begin
                bit p;
                p = next_bit() & next_bit() & next_bit();
                cyc(!p, 0, 0, next_bit(), "R2");
            end
            cyc(1, 0, 1, next_bit(), "R6");
            for (int i = 0; i < 9; i++) cyc(next_bit(), 0, 0, next_bit(), "R7");
        end

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule